// File: doc/BRIEF.md
# Buffered SPI Flash Master with Chip-Select Hold

This block drives one SPI flash device from a byte buffer that software reaches over a simple register bus. Software writes the bytes to send into the buffer, then writes a control word that gives the byte count and starts a burst. The block sends the bytes out in SPI mode 0, most significant bit first. As each byte completes, the byte captured from the device replaces it in the same buffer slot. When the burst ends, software reads the reply from the buffer.

Chip select can stay low from one burst to the next. A single flash command that is longer than the buffer, or a command followed by its data phase, can therefore be sent as several bursts. Only the burst that carries the final-piece flag releases chip select when it ends. A two-write sequence releases chip select at any idle moment. The clock divider register sets the SCK rate. A completion flag drives a level interrupt that software can mask.

Top module: `spibuf_master`

## Requirements
- R1: The bus sees the buffer at byte addresses 0 to DEPTH-1, using data bits 7:0. The control/status word is at address DEPTH and the divider at address DEPTH+2. Read data appears on `bus_rdata` in the cycle after the read strobe. Any other address reads as zero.
- R2: A burst sends buffer bytes from slot 0 upward, most significant bit first, in SPI mode 0. MOSI changes only while SCK is low, the device samples on the rising edge, and SCK stays low whenever chip select is high.
- R3: After each byte, the byte received on MISO during that byte is written into the buffer slot the sent byte came from.
- R4: In the control word, bits log2(DEPTH)-1:0 give the byte count and bit 15 starts a burst. A count of 0 sends the whole buffer (DEPTH bytes).
- R5: Bit 14 set with the start bit makes chip select go high after the last byte. With bit 14 clear, chip select stays low after the burst, and the next burst continues without chip select rising.
- R6: While idle, writing a word with bit 14 set and bit 15 clear, then writing zero, leaves chip select high.
- R7: Bit 12 (pending) sets when a burst ends, and writing 1 to bit 12 clears it. Bit 13 is the interrupt enable. `irq` is high exactly when both bits are set.
- R8: Control reads return busy in bit 15 from the start write until the burst ends. A write with the start bit during a burst changes neither the count nor the running burst.
- R9: SCK holds each level for max(divider,1)+1 system clocks. The divider resets to 2.
- R10: After reset, the control word reads 0, chip select is high, SCK is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | log2(DEPTH)+1 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Data to the device |
| spi_miso | input | 1 | Data from the device |
| spi_cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Level interrupt: pending and enabled |

## Verification
The bench builds the block with DEPTH = 16, giving a 4-bit count field and a 5-bit address. At that size, a count of 0 (a full-buffer burst) completes in a few hundred cycles, so the wrap-to-full case is exercised directly next to short bursts. The divider is run at 0, 2 and 4, which covers the clamp of low values to 1 and a slower rate. A device model in the bench returns a known byte sequence, so in-place replacement and chip-select hold across bursts can both be checked from the bus side.

// File: rtl/spibuf_pkg.sv
// Shared constants and types for the buffered SPI master.
// Assumes a 16-bit control word with flag bits at fixed positions.
package spibuf_pkg;
    localparam int CTRL_GO   = 15;
    localparam int CTRL_LAST = 14;
    localparam int CTRL_IE   = 13;
    localparam int CTRL_PEND = 12;
    localparam int REG_W     = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_LOAD, ST_LOW, ST_HIGH, ST_STORE
    } eng_state_t;

    typedef enum logic [1:0] {
        RG_NONE, RG_BUF, RG_CTRL, RG_DIV
    } rd_region_t;
endpackage

// File: rtl/spibuf_mem.sv
// Byte buffer with two ports: port A for the register bus, port B for the
// shift engine. Both ports read synchronously. On a write collision port B wins.
// Assumes DEPTH is a power of two.
module spibuf_mem #(
    parameter int DEPTH = 1024,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [IW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [IW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    // Write with engine priority, then register both read ports.
    always_ff @(posedge clk) begin
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end else if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/spibuf_engine.sv
// Mode-0 shift engine. It fetches each byte from the buffer, shifts it out
// MSB first, captures MISO on each rising SCK, and writes the received byte
// back to the same slot. It holds chip select between bursts unless the
// burst carries the final flag. Assumes go arrives only while idle.
module spibuf_engine #(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [IW-1:0] go_count,
    input  logic          go_last,
    input  logic          cs_release,
    input  logic [DW-1:0] div,
    input  logic          miso,
    input  logic [7:0]    mem_rdata,
    output logic [IW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          sck,
    output logic          mosi,
    output logic          cs_n
);
    import spibuf_pkg::*;

    eng_state_t    state;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic [7:0]    txsr;
    logic [7:0]    rxsr;
    logic [2:0]    bitn;
    logic [DW-1:0] tcnt;
    logic [DW-1:0] eff;
    logic          hold;
    logic          lastf;
    logic          tick;
    logic          at_end;

    // Clamp the divider so that each SCK level lasts at least two clocks.
    always_comb eff = (div == '0) ? DW'(1) : div;

    assign tick   = (tcnt == eff);
    assign at_end = (idx == last_idx);

    // Sequence fetch, shift and store for every byte of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            txsr     <= '0;
            rxsr     <= '0;
            bitn     <= '0;
            tcnt     <= '0;
            sck      <= 1'b0;
            hold     <= 1'b0;
            lastf    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        idx      <= '0;
                        last_idx <= go_count - 1'b1;
                        lastf    <= go_last;
                        hold     <= 1'b1;
                        state    <= ST_FETCH;
                    end else if (cs_release) begin
                        hold <= 1'b0;
                    end
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD: begin
                    txsr  <= mem_rdata;
                    bitn  <= '0;
                    tcnt  <= '0;
                    state <= ST_LOW;
                end
                ST_LOW: begin
                    if (tick) begin
                        sck   <= 1'b1;
                        rxsr  <= {rxsr[6:0], miso};
                        tcnt  <= '0;
                        state <= ST_HIGH;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sck  <= 1'b0;
                        tcnt <= '0;
                        if (bitn == 3'd7) begin
                            state <= ST_STORE;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            txsr  <= {txsr[6:0], 1'b0};
                            state <= ST_LOW;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STORE: begin
                    if (at_end) begin
                        hold  <= ~lastf;
                        state <= ST_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the buffer port and the status lines from the engine state.
    always_comb begin
        mem_addr  = idx;
        mem_we    = (state == ST_STORE);
        mem_wdata = rxsr;
        busy      = (state != ST_IDLE);
        done      = (state == ST_STORE) && at_end;
        mosi      = busy ? txsr[7] : 1'b0;
        cs_n      = ~hold;
    end
endmodule

// File: rtl/spibuf_regs.sv
// Register-bus slave. It decodes the buffer window, the control/status word
// and the divider, issues start and release pulses to the engine, keeps the
// pending and enable flags, and returns read data one cycle after the strobe.
// Assumes DEPTH is a power of two and at most 4096.
module spibuf_regs #(
    parameter int DEPTH = 1024,
    localparam int IW = $clog2(DEPTH),
    localparam int AW = IW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [AW-1:0]             bus_addr,
    input  logic [spibuf_pkg::REG_W-1:0] bus_wdata,
    output logic [spibuf_pkg::REG_W-1:0] bus_rdata,
    input  logic                      eng_busy,
    input  logic                      eng_done,
    input  logic [7:0]                buf_rdata,
    output logic                      buf_we,
    output logic [IW-1:0]             buf_addr,
    output logic [7:0]                buf_wdata,
    output logic                      go,
    output logic [IW-1:0]             cnt_q,
    output logic                      last_q,
    output logic                      cs_release,
    output logic [spibuf_pkg::REG_W-1:0] div_q,
    output logic                      busy_all,
    output logic                      pend_q,
    output logic                      ie_q,
    output logic                      irq
);
    import spibuf_pkg::*;

    localparam logic [AW-1:0] CTRL_ADDR = AW'(DEPTH);
    localparam logic [AW-1:0] DIV_ADDR  = AW'(DEPTH + 2);
    localparam int            PAD       = 12 - IW;

    logic             wr, rd, hit_buf, hit_ctrl, hit_div, ctrl_wr, start_ok;
    logic [REG_W-1:0] ctrl_view;
    logic [REG_W-1:0] snap_q;
    rd_region_t       region_q;

    // Decode the access type and which register the address selects.
    always_comb begin
        wr        = bus_sel & bus_wr;
        rd        = bus_sel & ~bus_wr;
        hit_buf   = ~bus_addr[AW-1];
        hit_ctrl  = (bus_addr == CTRL_ADDR);
        hit_div   = (bus_addr == DIV_ADDR);
        ctrl_wr   = wr & hit_ctrl;
        busy_all  = eng_busy | go;
        start_ok  = ctrl_wr & bus_wdata[CTRL_GO] & ~busy_all;
        cs_release = ctrl_wr & ~bus_wdata[CTRL_GO] & bus_wdata[CTRL_LAST] & ~busy_all;
        buf_we    = wr & hit_buf;
        buf_addr  = bus_addr[IW-1:0];
        buf_wdata = bus_wdata[7:0];
        ctrl_view = {busy_all, last_q, ie_q, pend_q, {PAD{1'b0}}, cnt_q};
        irq       = pend_q & ie_q;
    end

    // Latch the burst parameters and raise a one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go     <= 1'b0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else begin
            go <= start_ok;
            if (start_ok) begin
                cnt_q  <= bus_wdata[IW-1:0];
                last_q <= bus_wdata[CTRL_LAST];
            end
        end
    end

    // Keep the interrupt enable, the pending flag and the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
            div_q  <= REG_W'(2);
        end else begin
            if (ctrl_wr) ie_q <= bus_wdata[CTRL_IE];
            if (eng_done) begin
                pend_q <= 1'b1;
            end else if (ctrl_wr && bus_wdata[CTRL_PEND]) begin
                pend_q <= 1'b0;
            end
            if (wr && hit_div) div_q <= bus_wdata;
        end
    end

    // Capture which register a read selects, with a copy of its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= RG_NONE;
            snap_q   <= '0;
        end else if (rd) begin
            if (hit_buf)       region_q <= RG_BUF;
            else if (hit_ctrl) region_q <= RG_CTRL;
            else if (hit_div)  region_q <= RG_DIV;
            else               region_q <= RG_NONE;
            snap_q <= hit_ctrl ? ctrl_view : div_q;
        end else begin
            region_q <= RG_NONE;
        end
    end

    // Present the read data from the region captured in the previous cycle.
    always_comb begin
        case (region_q)
            RG_BUF:          bus_rdata = {8'h00, buf_rdata};
            RG_CTRL, RG_DIV: bus_rdata = snap_q;
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spibuf_master.sv
// Top level of the buffered SPI flash master. It joins the register slave,
// the shared byte buffer and the mode-0 shift engine.
// Assumes DEPTH is a power of two between 2 and 4096.
module spibuf_master #(
    parameter int DEPTH = 1024,
    localparam int IW = $clog2(DEPTH),
    localparam int AW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          spi_cs_n,
    output logic          irq
);
    logic          buf_we, eng_we, go, last_q, cs_release;
    logic          busy_all, pend_q, ie_q, eng_busy, eng_done;
    logic [IW-1:0] buf_addr, eng_addr, cnt_q;
    logic [7:0]    buf_wdata, buf_rdata, eng_wdata, eng_rdata;
    logic [15:0]   div_q;

    spibuf_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .go(go), .cnt_q(cnt_q), .last_q(last_q), .cs_release(cs_release),
        .div_q(div_q), .busy_all(busy_all), .pend_q(pend_q), .ie_q(ie_q),
        .irq(irq)
    );

    spibuf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk),
        .a_we(buf_we), .a_addr(buf_addr), .a_wdata(buf_wdata), .a_rdata(buf_rdata),
        .b_we(eng_we), .b_addr(eng_addr), .b_wdata(eng_wdata), .b_rdata(eng_rdata)
    );

    spibuf_engine #(.DEPTH(DEPTH), .DW(16)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_count(cnt_q), .go_last(last_q), .cs_release(cs_release),
        .div(div_q), .miso(spi_miso), .mem_rdata(eng_rdata),
        .mem_addr(eng_addr), .mem_we(eng_we), .mem_wdata(eng_wdata),
        .busy(eng_busy), .done(eng_done),
        .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
    );
endmodule

// File: rtl/spibuf_master_chk.sv
// Protocol and control checks for the buffered SPI master, bound to the top.
module spibuf_master_chk #(
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_sck,
    input logic          spi_mosi,
    input logic          spi_cs_n,
    input logic          eng_busy,
    input logic          eng_done,
    input logic          busy_all,
    input logic          pend_q,
    input logic [IW-1:0] cnt_q
);
    // R2: SCK stays low while chip select is released.
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R2: MOSI holds steady across a high SCK phase.
    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R5: chip select goes low only when a burst begins.
    p_cs_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> eng_busy);

    // R7: pending rises only after the engine finishes a burst.
    p_pend_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(eng_done));

    // R8: the latched count does not change while a burst runs.
    p_busy_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_all && $past(busy_all)) |-> $stable(cnt_q));
endmodule

bind spibuf_master spibuf_master_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .eng_busy(eng_busy), .eng_done(eng_done),
    .busy_all(busy_all), .pend_q(pend_q), .cnt_q(cnt_q)
);

// File: tb/spibuf_master_tb.sv
`timescale 1ns/1ps
module spibuf_master_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH) + 1;
    localparam logic [AW-1:0] A_CTRL = AW'(DEPTH);
    localparam logic [AW-1:0] A_DIV  = AW'(DEPTH + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          spi_sck, spi_mosi, spi_cs_n, irq;
    logic          spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    spibuf_master #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq(irq)
    );

    always #4 clk = ~clk;

    // Device model: fixed reply sequence, captures MOSI on rising SCK.
    function automatic logic [7:0] resp(int g);
        return 8'h3C ^ 8'(g * 29);
    endfunction

    int         gcnt = 0;
    int         bitc = 0;
    logic [7:0] cap_sh = '0;
    logic [7:0] cap_mem [128];
    int         cs_rises = 0;
    int         hi_cnt = 0;

    always @(posedge spi_sck) begin
        cap_sh = {cap_sh[6:0], spi_mosi};
        if (bitc == 7) begin
            cap_mem[gcnt % 128] = cap_sh;
            gcnt = gcnt + 1;
            bitc = 0;
        end else begin
            bitc = bitc + 1;
        end
    end

    always @(negedge spi_sck or negedge spi_cs_n) begin
        logic [7:0] r;
        if (!spi_cs_n) begin
            r = resp(gcnt);
            spi_miso = r[7 - bitc];
        end
    end

    always @(posedge spi_cs_n) cs_rises = cs_rises + 1;
    always @(posedge clk) if (spi_sck) hi_cnt = hi_cnt + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] cw(bit g, bit last, bit ie, int n);
        return {g, last, ie, 1'b0, 12'(n % DEPTH)};
    endfunction

    task automatic wait_idle(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_read(A_CTRL, v);
            if (!v[15]) return;
        end
        check(1'b0, tag, 1, 0);
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) bus_write(AW'(i), 16'(8'(seed + i * 37)));
    endtask

    // Compare MOSI bytes against the fill pattern and buffer against replies.
    task automatic verify_bytes(input int n, input int seed, input int g0, input string tag);
        logic [15:0] v;
        for (int i = 0; i < n; i++) begin
            check(cap_mem[(g0 + i) % 128] == 8'(seed + i * 37), {tag, " R2 mosi byte"},
                  cap_mem[(g0 + i) % 128], 8'(seed + i * 37));
            bus_read(AW'(i), v);
            check(v == {8'h00, resp(g0 + i)}, {tag, " R3 in-place reply"}, v, resp(g0 + i));
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        bus_read(A_CTRL, v);
        check(v == 16'h0000, "R10 ctrl after reset", v, 0);
        bus_read(A_DIV, v);
        check(v == 16'd2, "R9 divider reset value", v, 2);
        check(spi_cs_n == 1'b1, "R10 cs_n idle", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R10 sck idle", spi_sck, 0);
        check(irq == 1'b0, "R10 irq idle", irq, 0);
        bus_read(AW'(DEPTH + 4), v);
        check(v == 16'h0000, "R1 unmapped reads zero", v, 0);
    endtask

    task automatic t_buffer;
        logic [15:0] v;
        bus_write(AW'(0), 16'h00A7);
        bus_write(AW'(DEPTH - 1), 16'h0042);
        bus_read(AW'(0), v);
        check(v == 16'h00A7, "R1 buffer slot 0", v, 16'h00A7);
        bus_read(AW'(DEPTH - 1), v);
        check(v == 16'h0042, "R1 buffer last slot", v, 16'h0042);
    endtask

    task automatic t_basic;
        logic [15:0] v;
        int g0 = gcnt;
        fill(4, 8'h11);
        bus_write(A_CTRL, cw(1, 1, 1, 4));
        bus_read(A_CTRL, v);
        check(v[15] == 1'b1, "R8 busy during burst", v[15], 1);
        wait_idle("R8 basic burst end");
        check(gcnt - g0 == 4, "R4 byte count 4", gcnt - g0, 4);
        verify_bytes(4, 8'h11, g0, "basic");
        check(spi_cs_n == 1'b1, "R5 cs released after final burst", spi_cs_n, 1);
        bus_read(A_CTRL, v);
        check(v[12] == 1'b1, "R7 pending set", v[12], 1);
        check(irq == 1'b1, "R7 irq when enabled", irq, 1);
        bus_write(A_CTRL, 16'h3000);
        bus_read(A_CTRL, v);
        check(v[12] == 1'b0, "R7 pending cleared by write 1", v[12], 0);
        check(irq == 1'b0, "R7 irq drops after clear", irq, 0);
    endtask

    task automatic t_hold;
        int g0 = gcnt;
        int r0 = cs_rises;
        fill(3, 8'h50);
        bus_write(A_CTRL, cw(1, 0, 0, 3));
        wait_idle("R5 first piece");
        check(spi_cs_n == 1'b0, "R5 cs held after piece", spi_cs_n, 0);
        verify_bytes(3, 8'h50, g0, "hold1");
        fill(2, 8'h90);
        bus_write(A_CTRL, cw(1, 1, 0, 2));
        wait_idle("R5 second piece");
        verify_bytes(2, 8'h90, g0 + 3, "hold2");
        check(cs_rises - r0 == 1, "R5 single cs rise over two pieces", cs_rises - r0, 1);
        check(spi_cs_n == 1'b1, "R5 cs released at end", spi_cs_n, 1);
        bus_write(A_CTRL, 16'h1000);
    endtask

    task automatic t_force_off;
        bus_write(A_CTRL, cw(1, 0, 0, 1));
        wait_idle("R6 burst");
        check(spi_cs_n == 1'b0, "R6 cs held before release", spi_cs_n, 0);
        bus_write(A_CTRL, 16'h4000);
        bus_write(A_CTRL, 16'h0000);
        check(spi_cs_n == 1'b1, "R6 release sequence", spi_cs_n, 1);
        bus_write(A_CTRL, 16'h1000);
    endtask

    task automatic t_full;
        int g0 = gcnt;
        fill(DEPTH, 8'h07);
        bus_write(A_CTRL, cw(1, 1, 0, 0));
        wait_idle("R4 full burst");
        check(gcnt - g0 == DEPTH, "R4 count 0 sends whole buffer", gcnt - g0, DEPTH);
        verify_bytes(DEPTH, 8'h07, g0, "full");
        bus_write(A_CTRL, 16'h1000);
    endtask

    task automatic t_ignore_start;
        logic [15:0] v;
        int g0 = gcnt;
        bus_write(A_CTRL, cw(1, 1, 0, 2));
        bus_write(A_CTRL, cw(1, 1, 0, 5));
        wait_idle("R8 ignore");
        check(gcnt - g0 == 2, "R8 start during burst ignored", gcnt - g0, 2);
        bus_read(A_CTRL, v);
        check(v[3:0] == 4'd2, "R8 count unchanged", v[3:0], 2);
        bus_write(A_CTRL, 16'h1000);
    endtask

    task automatic t_mask;
        logic [15:0] v;
        bus_write(A_CTRL, cw(1, 1, 0, 1));
        wait_idle("R7 masked burst");
        bus_read(A_CTRL, v);
        check(v[12] == 1'b1, "R7 pending set while masked", v[12], 1);
        check(irq == 1'b0, "R7 irq masked", irq, 0);
        bus_write(A_CTRL, 16'h1000);
    endtask

    task automatic t_div(input int d, input int per_level);
        int h0;
        bus_write(A_DIV, 16'(d));
        h0 = hi_cnt;
        bus_write(A_CTRL, cw(1, 1, 0, 1));
        wait_idle("R9 div burst");
        check(hi_cnt - h0 == 8 * per_level, "R9 sck high time", hi_cnt - h0, 8 * per_level);
        bus_write(A_CTRL, 16'h1000);
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_buffer();
        t_basic();
        t_hold();
        t_force_off();
        t_full();
        t_ignore_start();
        t_mask();
        t_div(0, 2);
        t_div(4, 5);
        t_div(2, 3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule